// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block is an I2C bus target that gives a host an 8-bit general-purpose parallel port. The host sends the device address. It then sends a command byte that chooses one of four 8-bit registers: the input port, the output port, the polarity mask or the direction control. After that it writes data bytes into the chosen register, or it issues a repeated start and reads the register back. Each pin can be an input or an output. Its value as an input can be returned inverted, one bit at a time.

An active-low open-drain interrupt reports that an input has moved away from a stored snapshot. The snapshot is taken each time the host reads the input register. The block is clocked by a system clock that runs much faster than SCL. SDA, SCL and the pins pass through two-flop synchronisers. SDA is never driven high: the block only pulls it low or releases it, and it does the same with the interrupt line.

Top module: `gpio_xpander`

## Requirements
- R1: The 7-bit target address is {HI, addr_pins}, where HI is 4'b0100 when ALT_BASE=0 and 4'b0111 when ALT_BASE=1. A matching address byte is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and the block ignores every byte until the next start.
- R2: The first byte after a write address is a command byte. Bits [1:0] pick the register (0 input, 1 output, 2 polarity, 3 direction) and bits [7:2] are ignored. Every later data byte in the same transfer goes to that same register, so the pointer does not advance. Writes to register 0 change nothing.
- R3: After reset, direction = 0xFF, output = 0xFF and polarity = 0x00. pin_oe is 0x00, and irq_pull and sda_pull are both 0.
- R4: A direction bit of 1 makes the pin an input with its driver off (pin_oe[i]=0). A direction bit of 0 makes it an output with pin_oe[i]=1 and pin_o[i] equal to the output register bit. pin_o always follows the output register.
- R5: Reading register 0 returns the synchronised pin levels XOR the polarity register.
- R6: All four registers can be read. When the host acknowledges a read byte, the next byte comes from the same register.
- R7: irq_pull is 1 whenever a pin set as an input differs from its snapshot bit. Pins set as outputs never raise it.
- R8: A read of register 0 loads the current pin levels into the snapshot, which clears the interrupt. A pin that returns to its snapshot value also withdraws its request.
- R9: The snapshot resets to all ones, so an input that is low after reset raises the interrupt until register 0 is read.
- R10: sda_pull changes only while SCL is low. After a stop, the target releases SDA and waits for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Port pad levels |
| pin_o | output | 8 | Output register value to the pads |
| pin_oe | output | 8 | Per-pin driver enable, 1 drives |
| irq_pull | output | 1 | 1 pulls the interrupt line low |

## Verification
The checker watches four things on every cycle:
- SDA is released whenever the protocol engine is idle, and sda_pull never moves while SCL is high.
- The interrupt stays quiet while every pin is an output.
- A snapshot taken over stable pins clears the interrupt two cycles later.
- The register pointer holds still while a byte is being shifted out.

Only the bench scenarios can show the rest: address matching for both address bases, the ignored command bits, the absence of auto-increment, the reset values, polarity inversion, the direction effect on the pads, and the interrupt rising and falling as inputs move.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 2;

  localparam logic [PTR_W-1:0] REG_IN  = 2'd0;
  localparam logic [PTR_W-1:0] REG_OUT = 2'd1;
  localparam logic [PTR_W-1:0] REG_POL = 2'd2;
  localparam logic [PTR_W-1:0] REG_DIR = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } gx_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } gx_kind_e;

  function automatic logic [3:0] addr_hi(input bit alt);
    return alt ? 4'b0111 : 4'b0100;
  endfunction
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gx_i2c_target.sv
module gx_i2c_target
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              rd_snap,
  output logic              idle,
  output logic              in_tx
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  gx_state_e         state_q, state_d;
  gx_kind_e          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              scl_d1, sda_d1;
  logic              rise, fall, start_c, stop_c;

  assign rise    = scl_s & ~scl_d1;
  assign fall    = ~scl_s & scl_d1;
  assign start_c = scl_s & scl_d1 & sda_d1 & ~sda_s;
  assign stop_c  = scl_s & scl_d1 & ~sda_d1 & sda_s;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    wr_en   = 1'b0;
    rd_snap = 1'b0;
    if (stop_c) begin
      state_d = ST_IDLE;
    end else if (start_c) begin
      state_d = ST_RX;
      kind_d  = K_ADDR;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (fall && cnt_q == LAST) begin
            cnt_d = '0;
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q[7:1] == dev_addr) begin
                  rw_d    = sh_q[0];
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              K_CMD: begin
                ptr_d   = sh_q[PTR_W-1:0];
                state_d = ST_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (fall) begin
            cnt_d = '0;
            if (kind_q == K_ADDR && rw_q) begin
              sh_d    = rd_data;
              rd_snap = (ptr_q == REG_IN);
              state_d = ST_TX;
            end else begin
              state_d = ST_RX;
              kind_d  = (kind_q == K_ADDR) ? K_CMD : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (fall) begin
            if (cnt_q == LAST) begin
              cnt_d   = '0;
              state_d = ST_MACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (rise) begin
            nack_d = sda_s;
          end else if (fall) begin
            if (!nack_q) begin
              sh_d    = rd_data;
              rd_snap = (ptr_q == REG_IN);
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= REG_IN;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      scl_d1  <= 1'b1;
      sda_d1  <= 1'b1;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      scl_d1  <= scl_s;
      sda_d1  <= sda_s;
    end
  end

  assign sda_pull = (state_q == ST_ACK) | ((state_q == ST_TX) & ~sh_q[BYTE_W-1]);
  assign wr_data  = sh_q;
  assign ptr      = ptr_q;
  assign idle     = (state_q == ST_IDLE);
  assign in_tx    = (state_q == ST_TX);
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
  import gx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              rd_snap,
  input  logic [BYTE_W-1:0] pin_s,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe,
  output logic [BYTE_W-1:0] dir,
  output logic              irq_pull
);
  logic [BYTE_W-1:0] out_q, out_d, pol_q, pol_d, dir_q, dir_d, snap_q, snap_d;
  logic [BYTE_W-1:0] diff;
  logic              irq_q, irq_d;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign pin_oe[i] = ~dir_q[i];
    assign pin_o[i]  = out_q[i];
    assign diff[i]   = (pin_s[i] ^ snap_q[i]) & dir_q[i];
  end

  always_comb begin
    out_d  = out_q;
    pol_d  = pol_q;
    dir_d  = dir_q;
    snap_d = snap_q;
    if (wr_en) begin
      unique case (ptr)
        REG_OUT: out_d = wr_data;
        REG_POL: pol_d = wr_data;
        REG_DIR: dir_d = wr_data;
        default: ;
      endcase
    end
    if (rd_snap) snap_d = pin_s;
    irq_d = |diff;
  end

  always_comb begin
    unique case (ptr)
      REG_IN:  rd_data = pin_s ^ pol_q;
      REG_OUT: rd_data = out_q;
      REG_POL: rd_data = pol_q;
      default: rd_data = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      pol_q  <= '0;
      dir_q  <= '1;
      snap_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      out_q  <= out_d;
      pol_q  <= pol_d;
      dir_q  <= dir_d;
      snap_q <= snap_d;
      irq_q  <= irq_d;
    end
  end

  assign dir      = dir_q;
  assign irq_pull = irq_q;
endmodule

// File: rtl/gpio_xpander.sv
module gpio_xpander
  import gx_pkg::*;
#(
  parameter bit ALT_BASE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic [2:0] addr_pins,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe,
  output logic       irq_pull
);
  localparam logic [3:0] HI = addr_hi(ALT_BASE);

  logic [1:0]        rst_ff;
  logic              rst_n_s;
  logic [1:0]        bus_s;
  logic              scl_s, sda_s;
  logic [BYTE_W-1:0] pin_s, rd_data, wr_data, dir_q;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en, rd_snap, idle, in_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  gx_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n_s), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  gx_sync #(.W(BYTE_W), .RST_VAL('1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_s), .d(pin_i), .q(pin_s)
  );

  gx_i2c_target u_target (
    .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .sda_s(sda_s),
    .dev_addr({HI, addr_pins}), .rd_data(rd_data), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr), .rd_snap(rd_snap),
    .idle(idle), .in_tx(in_tx)
  );

  gx_regfile u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wr_data),
    .ptr(ptr), .rd_snap(rd_snap), .pin_s(pin_s), .rd_data(rd_data),
    .pin_o(pin_o), .pin_oe(pin_oe), .dir(dir_q), .irq_pull(irq_pull)
  );
endmodule

// File: rtl/gx_checker.sv
module gx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull,
  input logic       irq_pull,
  input logic [7:0] dir,
  input logic [7:0] pin_s,
  input logic       rd_snap,
  input logic [1:0] ptr,
  input logic       in_tx,
  input logic       idle
);
  // R10: the target leaves SDA alone while idle
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);

  // R10: SDA drive moves only while SCL is low
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s);

  // R7: pins that are all outputs never raise the interrupt
  p_outputs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dir) == 8'h00) |-> !irq_pull);

  // R8: a snapshot over stable pins clears the request
  p_snap_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_snap, 2) && ($past(pin_s, 1) == $past(pin_s, 2))) |-> !irq_pull);

  // R6: the pointer holds while a byte is shifted out
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && $past(in_tx)) |-> $stable(ptr));
endmodule

bind gpio_xpander gx_checker u_gx_checker (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .sda_pull(sda_pull),
  .irq_pull(irq_pull), .dir(dir_q), .pin_s(pin_s), .rd_snap(rd_snap),
  .ptr(ptr), .in_tx(in_tx), .idle(idle)
);

// File: tb/test_gpio_xpander.sv
module test_gpio_xpander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h4A, AR = 8'h4B;
  localparam logic [7:0] ALT_W = 8'h7A;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic [7:0] ext;
  logic [2:0] apins;
  logic sda_pull, sda_pull_alt, irq_pull, irq_alt;
  logic [7:0] pin_o, pin_oe, pads, pin_o_alt, pin_oe_alt;
  logic sda_line;
  int n_chk = 0, n_fail = 0;

  assign sda_line = m_sda & ~sda_pull & ~sda_pull_alt;
  assign pads = (pin_oe & pin_o) | (~pin_oe & ext);

  gpio_xpander i_gpio_xpander (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull(sda_pull),
    .addr_pins(apins), .pin_i(pads), .pin_o(pin_o), .pin_oe(pin_oe), .irq_pull(irq_pull)
  );

  gpio_xpander #(.ALT_BASE(1'b1)) i_gpio_xpander_alt (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull(sda_pull_alt),
    .addr_pins(apins), .pin_i(ext), .pin_o(pin_o_alt), .pin_oe(pin_oe_alt), .irq_pull(irq_alt)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_sda = ~give_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q); m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    i2c_start; wbyte(AW, a); wbyte(cmd, a); wbyte(d, a); i2c_stop;
  endtask

  task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    i2c_start; wbyte(AW, a); wbyte(cmd, a);
    i2c_start; wbyte(AR, a); rbyte(1'b0, d); i2c_stop;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R3 pin_oe", pin_oe, 8'h00);
    check("R3 irq_pull", {7'b0, irq_pull}, 8'h00);
    check("R3 sda_pull", {7'b0, sda_pull}, 8'h00);
    rd_reg(8'h03, d); check("R3 dir", d, 8'hFF);
    rd_reg(8'h01, d); check("R3 out", d, 8'hFF);
    rd_reg(8'h02, d); check("R3 pol", d, 8'h00);
    ext = 8'hFE; wq(10);
    check("R9 low pin vs reset snapshot", {7'b0, irq_pull}, 8'h01);
    rd_reg(8'h00, d); check("R5 input read", d, 8'hFE);
    wq(10); check("R8 read clears", {7'b0, irq_pull}, 8'h00);
    ext = 8'hFF; wq(10); check("R7 change raises", {7'b0, irq_pull}, 8'h01);
    rd_reg(8'h00, d); wq(10); check("R8 read clears again", {7'b0, irq_pull}, 8'h00);
  endtask

  task automatic t_addr;
    logic a;
    logic [7:0] d;
    i2c_start; wbyte(8'h4E, a); check("R1 wrong address nack", {7'b0, a}, 8'h00);
    wbyte(8'h01, a); wbyte(8'h00, a); i2c_stop;
    check("R10 released after stop", {7'b0, sda_pull}, 8'h00);
    rd_reg(8'h01, d); check("R1 ignored write", d, 8'hFF);
    i2c_start; wbyte(AW, a); check("R1 own address ack", {7'b0, a}, 8'h01); i2c_stop;
    i2c_start; wbyte(ALT_W, a); check("R1 alternate base ack", {7'b0, a}, 8'h01);
    wbyte(8'h01, a); wbyte(8'h3C, a); i2c_stop;
    check("R1 alternate base write", pin_o_alt, 8'h3C);
    check("R1 main ignores alt address", pin_o, 8'hFF);
  endtask

  task automatic t_cmd;
    logic a;
    logic [7:0] d;
    i2c_start; wbyte(AW, a); wbyte(8'h01, a); wbyte(8'h12, a); wbyte(8'h34, a); i2c_stop;
    rd_reg(8'h01, d); check("R2 no auto-increment out", d, 8'h34);
    rd_reg(8'h02, d); check("R2 no auto-increment pol", d, 8'h00);
    wr_reg(8'hFE, 8'h0F);
    rd_reg(8'h02, d); check("R2 upper command bits ignored", d, 8'h0F);
    wr_reg(8'h02, 8'h00);
    wr_reg(8'h00, 8'h00);
    rd_reg(8'h01, d); check("R2 input write no effect out", d, 8'h34);
    rd_reg(8'h00, d); check("R2 input write no effect in", d, 8'hFF);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr_reg(8'h03, 8'hF0); wr_reg(8'h01, 8'hA5);
    check("R4 pin_oe", pin_oe, 8'h0F);
    check("R4 pin_o", pin_o, 8'hA5);
    rd_reg(8'h00, d); check("R5 input mixes driven pads", d, 8'hF5);
    wr_reg(8'h03, 8'hFF);
    check("R4 back to inputs", pin_oe, 8'h00);
  endtask

  task automatic t_pol;
    logic [7:0] d;
    wr_reg(8'h02, 8'h3C); ext = 8'h5A; wq(10);
    rd_reg(8'h00, d); check("R5 polarity inversion", d, 8'h66);
    wr_reg(8'h02, 8'h00);
    rd_reg(8'h00, d); check("R5 plain read", d, 8'h5A);
    ext = 8'hFF; wq(10); rd_reg(8'h00, d);
  endtask

  task automatic t_multi;
    logic a;
    logic [7:0] d0, d1;
    wr_reg(8'h02, 8'h96);
    i2c_start; wbyte(AW, a); wbyte(8'h02, a);
    i2c_start; wbyte(AR, a); rbyte(1'b1, d0); rbyte(1'b0, d1); i2c_stop;
    check("R6 first read byte", d0, 8'h96);
    check("R6 repeated read same register", d1, 8'h96);
    wr_reg(8'h02, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    rd_reg(8'h00, d);
    ext = 8'hF7; wq(10); check("R7 input change raises", {7'b0, irq_pull}, 8'h01);
    ext = 8'hFF; wq(10); check("R8 return to snapshot clears", {7'b0, irq_pull}, 8'h00);
    ext = 8'h7F; wq(10); check("R7 second change raises", {7'b0, irq_pull}, 8'h01);
    rd_reg(8'h00, d); check("R5 read during irq", d, 8'h7F);
    wq(10); check("R8 read clears irq", {7'b0, irq_pull}, 8'h00);
    ext = 8'hFF; wq(10); rd_reg(8'h00, d);
  endtask

  task automatic t_excl;
    logic [7:0] d;
    wr_reg(8'h01, 8'h00); wr_reg(8'h03, 8'h0F);
    rd_reg(8'h00, d); check("R4 outputs seen on input read", d, 8'h0F);
    wr_reg(8'h01, 8'hF0); wq(10);
    check("R7 output pin change excluded", {7'b0, irq_pull}, 8'h00);
    ext = 8'hFE; wq(10);
    check("R7 input pin still raises", {7'b0, irq_pull}, 8'h01);
    ext = 8'hFF; wr_reg(8'h03, 8'hFF); wr_reg(8'h01, 8'hFF); rd_reg(8'h00, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; ext = 8'hFF; apins = 3'b101;
    wq(5); rst_n = 1'b1; wq(10);
    t_reset;
    t_addr;
    t_cmd;
    t_dir;
    t_pol;
    t_multi;
    t_irq;
    t_excl;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule